// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Evaluation

This block is the integer arithmetic slice of a processor pipeline. It adds, subtracts, compares and applies bitwise logic to two 32-bit operands. It keeps four condition flags: negative (N), zero (Z), signed overflow (V) and carry/borrow (C). The carry flag feeds back into the add-with-carry and subtract-with-borrow operations, so wide arithmetic can be chained across several words.

Beside the ALU sits a combinational branch evaluator. It reads the registered flags and a 4-bit condition selector and decides whether a conditional PC-relative branch is taken. In parallel it forms the branch target from the current PC and a signed 8-bit halfword displacement.

An operation issued with `opValid` high takes effect on the next rising clock edge. The result register, the write strobe and the flags update together on that edge.

Top module: `alu_flag_branch`

## Requirements
- R1: After any operation that updates flags (opcodes 0 to 8), N equals bit 31 of the 32-bit value computed by that operation, and Z is 1 exactly when that value is zero. This holds even when the value is not written, as with compare.
- R2: Opcode 0 (add) yields opA+opB and opcode 1 (add with carry) yields opA+opB+C. In both, C becomes the carry out of bit 31. V is set when two operands of equal sign produce a result of the other sign.
- R3: Opcode 2 (subtract) yields opA-opB and opcode 3 (subtract with borrow) yields opA-opB-C. In both, C becomes 1 when the unsigned subtraction borrows. V is set when the operands differ in sign and the result's sign differs from opA's.
- R4: Opcodes 5 (and), 6 (or), 7 (xor) and 8 (not, giving ~opB) write the bitwise result and update N and Z only. V and C keep their previous values.
- R5: Opcode 4 (compare) sets all four flags exactly as subtract would. `resWrite` stays 0 and `result` keeps its previous value.
- R6: `result`, `resWrite` and the flags change only on the rising edge after a cycle with `opValid`=1. `resWrite` is 1 for exactly that one cycle after a writing opcode (0 to 3 and 5 to 8). When `opValid`=0, or when the opcode is 9 to 15, the flags and `result` hold and `resWrite` is 0.
- R7: Signed conditions use N, Z and V. Selector 2 (gt) is !Z & (N==V). Selector 3 (ge) is N==V. Selector 4 (lt) is N!=V. Selector 5 (le) is Z | (N!=V).
- R8: Unsigned conditions use C and Z. Selector 6 (ugt) is !Z & !C. Selector 7 (uge) is !C. Selector 8 (ult) is C. Selector 9 (ule) is Z | C.
- R9: Selector 0 (eq) is Z and selector 1 (ne) is !Z. Selectors 10 to 15 are never taken. `condTaken` is combinational from the registered flags.
- R10: `branchTarget` equals pcIn plus twice the sign-extended 8-bit `disp`, modulo 2^32. It is combinational.
- R11: While `rstN` is low, `result` is 0, `resWrite` is 0 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation issued this cycle |
| opCode | input | 4 | Operation code (see R2 to R6) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| result | output | 32 | Last written ALU result |
| resWrite | output | 1 | One-cycle strobe: result was written by the last operation |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Signed overflow flag |
| flagC | output | 1 | Carry / borrow flag |
| condSel | input | 4 | Branch condition selector (see R7 to R9) |
| condTaken | output | 1 | Branch condition holds on the current flags |
| pcIn | input | 32 | Current program counter |
| disp | input | 8 | Signed halfword displacement |
| branchTarget | output | 32 | pcIn + 2*disp |

## Verification
The hardest states to reach are those that depend on flag history. One is a subtract-with-borrow that overflows only because of the incoming borrow. Another is a logic operation that must preserve V and C while both are set. Neither can be reached from reset in a single operation.

The stimulus reaches them by chaining operations. A 0x80000000 + 0x80000000 add first sets V, C and Z together, and logic operations follow while those flags are still set. A compare that borrows then leaves C=1, which feeds both an add-with-carry that wraps to zero and a borrow-subtract from 0x80000000 that overflows. The full set of sixteen condition selectors is swept after each distinct flag pattern.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int COND_W = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_FLAG  = 2'd2,
    CIN_FLAGN = 2'd3
  } carrySel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      load;
    logic      writeDest;
    logic      isLogic;
    logic      invertB;
    carrySel_e carrySel;
    logicSel_e logicSel;
  } aluStrobe_t;

  localparam logic [COND_W-1:0] COND_EQ  = 4'd0;
  localparam logic [COND_W-1:0] COND_NE  = 4'd1;
  localparam logic [COND_W-1:0] COND_GT  = 4'd2;
  localparam logic [COND_W-1:0] COND_GE  = 4'd3;
  localparam logic [COND_W-1:0] COND_LT  = 4'd4;
  localparam logic [COND_W-1:0] COND_LE  = 4'd5;
  localparam logic [COND_W-1:0] COND_UGT = 4'd6;
  localparam logic [COND_W-1:0] COND_UGE = 4'd7;
  localparam logic [COND_W-1:0] COND_ULT = 4'd8;
  localparam logic [COND_W-1:0] COND_ULE = 4'd9;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (opValid) begin
      strobe.load      = 1'b1;
      strobe.writeDest = 1'b1;
      case (opCode)
        OP_ADD: strobe.carrySel = CIN_ZERO;
        OP_ADC: strobe.carrySel = CIN_FLAG;
        OP_SUB: begin
          strobe.invertB  = 1'b1;
          strobe.carrySel = CIN_ONE;
        end
        OP_SBB: begin
          strobe.invertB  = 1'b1;
          strobe.carrySel = CIN_FLAGN;
        end
        OP_CMP: begin
          strobe.invertB   = 1'b1;
          strobe.carrySel  = CIN_ONE;
          strobe.writeDest = 1'b0;
        end
        OP_AND: begin
          strobe.isLogic  = 1'b1;
          strobe.logicSel = LG_AND;
        end
        OP_OR: begin
          strobe.isLogic  = 1'b1;
          strobe.logicSel = LG_OR;
        end
        OP_XOR: begin
          strobe.isLogic  = 1'b1;
          strobe.logicSel = LG_XOR;
        end
        OP_NOT: begin
          strobe.isLogic  = 1'b1;
          strobe.logicSel = LG_NOT;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_flag_datapath.sv
module alu_flag_datapath
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resWrite,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bEff;
  logic              carryIn;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] nextRes;
  logic              nextC;
  logic              nextV;

  assign bEff = strobe.invertB ? ~opB : opB;

  always_comb begin
    case (strobe.carrySel)
      CIN_ZERO:  carryIn = 1'b0;
      CIN_ONE:   carryIn = 1'b1;
      CIN_FLAG:  carryIn = flagC;
      CIN_FLAGN: carryIn = ~flagC;
      default:   carryIn = 1'b0;
    endcase
  end

  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    case (strobe.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOT:  logicRes = ~opB;
      default: logicRes = '0;
    endcase
  end

  assign nextRes = strobe.isLogic ? logicRes : sumWide[MSB:0];
  // A subtract is an add of the inverted operand; its borrow is the missing carry.
  assign nextC   = strobe.invertB ? ~sumWide[DATA_W] : sumWide[DATA_W];
  assign nextV   = (opA[MSB] == bEff[MSB]) && (sumWide[MSB] != opA[MSB]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      resWrite <= 1'b0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
    end else begin
      resWrite <= strobe.load & strobe.writeDest;
      if (strobe.load) begin
        flagN <= nextRes[MSB];
        flagZ <= (nextRes == '0);
        if (!strobe.isLogic) begin
          flagV <= nextV;
          flagC <= nextC;
        end
        if (strobe.writeDest) result <= nextRes;
      end
    end
  end

endmodule

// File: rtl/alu_flag_branch_eval.sv
module alu_flag_branch_eval
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagV,
  input  logic              flagC,
  input  logic [COND_W-1:0] condSel,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DISP_W-1:0] disp,
  output logic              condTaken,
  output logic [DATA_W-1:0] branchTarget
);

  localparam int EXT_W = DATA_W - DISP_W - 1;

  logic signMismatch;
  assign signMismatch = flagN ^ flagV;

  always_comb begin
    case (condSel)
      COND_EQ:  condTaken = flagZ;
      COND_NE:  condTaken = ~flagZ;
      COND_GT:  condTaken = ~flagZ & ~signMismatch;
      COND_GE:  condTaken = ~signMismatch;
      COND_LT:  condTaken = signMismatch;
      COND_LE:  condTaken = flagZ | signMismatch;
      COND_UGT: condTaken = ~flagZ & ~flagC;
      COND_UGE: condTaken = ~flagC;
      COND_ULT: condTaken = flagC;
      COND_ULE: condTaken = flagZ | flagC;
      default:  condTaken = 1'b0;
    endcase
  end

  assign branchTarget = pcIn + {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};

endmodule

// File: rtl/alu_flag_branch.sv
module alu_flag_branch
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resWrite,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  input  logic [COND_W-1:0] condSel,
  output logic              condTaken,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DISP_W-1:0] disp,
  output logic [DATA_W-1:0] branchTarget
);

  aluStrobe_t strobe;

  alu_flag_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  alu_flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .resWrite (resWrite),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC)
  );

  alu_flag_branch_eval #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_br (
    .flagN        (flagN),
    .flagZ        (flagZ),
    .flagV        (flagV),
    .flagC        (flagC),
    .condSel      (condSel),
    .pcIn         (pcIn),
    .disp         (disp),
    .condTaken    (condTaken),
    .branchTarget (branchTarget)
  );

endmodule

// File: rtl/alu_flag_branch_chk.sv
module alu_flag_branch_chk
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] result,
  input logic              resWrite,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagV,
  input logic              flagC,
  input logic [COND_W-1:0] condSel,
  input logic              condTaken,
  input logic [DATA_W-1:0] pcIn,
  input logic [DATA_W-1:0] branchTarget
);

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    resWrite |-> (flagN == result[DATA_W-1]) && (flagZ == (result == '0))); // R1

  AST_LOGIC_KEEPS_VC: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode inside {OP_AND, OP_OR, OP_XOR, OP_NOT})) |=> $stable(flagV) && $stable(flagC)); // R4

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> !resWrite && $stable(result)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resWrite && $stable(result) && $stable({flagN, flagZ, flagV, flagC})); // R6

  AST_ULT_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == COND_ULT) |-> condTaken == flagC); // R8

  AST_NE_OPPOSES_Z: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == COND_NE) |-> condTaken != flagZ); // R9

  AST_TARGET_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    branchTarget[0] == pcIn[0]); // R10

endmodule

bind alu_flag_branch alu_flag_branch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opCode       (opCode),
  .result       (result),
  .resWrite     (resWrite),
  .flagN        (flagN),
  .flagZ        (flagZ),
  .flagV        (flagV),
  .flagC        (flagC),
  .condSel      (condSel),
  .condTaken    (condTaken),
  .pcIn         (pcIn),
  .branchTarget (branchTarget)
);

// File: tb/tb_alu_flag_branch.sv
module tb_alu_flag_branch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        resWrite;
  logic        flagN, flagZ, flagV, flagC;
  logic [3:0]  condSel = '0;
  logic        condTaken;
  logic [31:0] pcIn = '0;
  logic [7:0]  disp = '0;
  logic [31:0] branchTarget;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic        n, z, v, c;
    string       tag;
  } item_t;

  item_t scoreQ[$];

  logic [31:0] mRes = '0;
  logic        mN = 0, mZ = 0, mV = 0, mC = 0;

  always #2 clk = ~clk;

  alu_flag_branch dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opA(opA), .opB(opB),
    .result(result), .resWrite(resWrite), .flagN(flagN), .flagZ(flagZ), .flagV(flagV),
    .flagC(flagC), .condSel(condSel), .condTaken(condTaken), .pcIn(pcIn), .disp(disp),
    .branchTarget(branchTarget)
  );

  // Driver: drives one operation at a negedge and pushes the expected outcome.
  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [32:0] wide;
    logic [31:0] res;
    logic        wr, upd, arith, cIn;
    longint      sa, sbv, ss;
    item_t       it;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opA = a; opB = b;
    sa = longint'($signed(a));
    sbv = longint'($signed(b));
    res = '0; wr = 0; upd = 1; arith = 1; wide = '0; ss = 0;
    case (op)
      4'd0, 4'd1: begin
        cIn = (op == 4'd1) ? mC : 1'b0;
        wide = {1'b0, a} + {1'b0, b} + {32'd0, cIn};
        res = wide[31:0]; wr = 1;
        ss = sa + sbv + longint'(cIn);
        mC = wide[32];
      end
      4'd2, 4'd3, 4'd4: begin
        cIn = (op == 4'd3) ? mC : 1'b0;
        res = a - b - {31'd0, cIn}; wr = (op != 4'd4);
        ss = sa - sbv - longint'(cIn);
        mC = ({1'b0, a} < ({1'b0, b} + {32'd0, cIn}));
      end
      4'd5: begin res = a & b; wr = 1; arith = 0; end
      4'd6: begin res = a | b; wr = 1; arith = 0; end
      4'd7: begin res = a ^ b; wr = 1; arith = 0; end
      4'd8: begin res = ~b;    wr = 1; arith = 0; end
      default: begin upd = 0; arith = 0; end
    endcase
    if (upd) begin
      mN = res[31];
      mZ = (res == 32'd0);
      if (arith) mV = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end
    if (wr) mRes = res;
    it.res = mRes; it.wr = wr; it.n = mN; it.z = mZ; it.v = mV; it.c = mC; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opValid = 1'b0;
    end
  endtask

  // Monitor: one expected item per cycle in which an operation was issued.
  logic monFired;
  always @(posedge clk) begin
    monFired = opValid;
    #1;
    if (monFired && rstN && !done) begin
      checks++;
      if (scoreQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: result with no expected item, got res=%h", result);
      end else begin
        item_t it;
        it = scoreQ.pop_front();
        if (result !== it.res || resWrite !== it.wr ||
            {flagN, flagZ, flagV, flagC} !== {it.n, it.z, it.v, it.c}) begin
          errors++;
          $display("FAIL %s: got res=%h wr=%b nzvc=%b%b%b%b, expected res=%h wr=%b nzvc=%b%b%b%b",
                   it.tag, result, resWrite, flagN, flagZ, flagV, flagC,
                   it.res, it.wr, it.n, it.z, it.v, it.c);
        end
      end
    end
  end

  function automatic logic expCond(input logic [3:0] s);
    case (s)
      4'd0: return mZ;
      4'd1: return !mZ;
      4'd2: return !mZ && (mN == mV);
      4'd3: return mN == mV;
      4'd4: return mN != mV;
      4'd5: return mZ || (mN != mV);
      4'd6: return !mZ && !mC;
      4'd7: return !mC;
      4'd8: return mC;
      4'd9: return mZ || mC;
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkCond(input logic [3:0] s);
    string tag;
    logic  e;
    @(negedge clk);
    opValid = 1'b0;
    condSel = s;
    #1;
    if (s >= 4'd2 && s <= 4'd5)      tag = "R7 signed";
    else if (s >= 4'd6 && s <= 4'd9) tag = "R8 unsigned";
    else                             tag = "R9 eq/ne/unused";
    e = expCond(s);
    checks++;
    if (condTaken !== e) begin
      errors++;
      $display("FAIL %s sel=%0d nzvc=%b%b%b%b: got %b expected %b",
               tag, s, mN, mZ, mV, mC, condTaken, e);
    end
  endtask

  task automatic allConds();
    for (int s = 0; s < 16; s++) checkCond(4'(s));
  endtask

  task automatic checkHold();
    @(negedge clk);
    opValid = 1'b0;
    checks++;
    if (result !== mRes || resWrite !== 1'b0 || {flagN, flagZ, flagV, flagC} !== {mN, mZ, mV, mC}) begin
      errors++;
      $display("FAIL R6 hold: got res=%h wr=%b nzvc=%b%b%b%b expected res=%h wr=0 nzvc=%b%b%b%b",
               result, resWrite, flagN, flagZ, flagV, flagC, mRes, mN, mZ, mV, mC);
    end
  endtask

  task automatic checkTarget(input logic [31:0] pc, input logic [7:0] d);
    logic [31:0] e;
    @(negedge clk);
    pcIn = pc; disp = d;
    #1;
    e = pc + 32'($signed(d)) * 32'd2;
    checks++;
    if (branchTarget !== e) begin
      errors++;
      $display("FAIL R10 target pc=%h disp=%h: got %h expected %h", pc, d, branchTarget, e);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'd0 || resWrite !== 1'b0 || {flagN, flagZ, flagV, flagC} !== 4'b0000) begin
      errors++;
      $display("FAIL R11 reset: got res=%h wr=%b nzvc=%b%b%b%b expected all zero",
               result, resWrite, flagN, flagZ, flagV, flagC);
    end
    rstN = 1'b1;
    allConds();

    issue(4'd0, 32'd5, 32'd7, "R2 add");
    issue(4'd0, 32'h7FFF_FFFF, 32'd1, "R2 add signed overflow");
    issue(4'd0, 32'h8000_0000, 32'h8000_0000, "R2 add carry+overflow+zero");
    allConds();
    issue(4'd7, 32'h0000_00F0, 32'h0000_000F, "R4 xor keeps V,C");
    issue(4'd5, 32'hFFFF_0000, 32'h0000_FFFF, "R4 and zero keeps V,C");
    allConds();
    issue(4'd6, 32'h8000_0000, 32'h0000_0001, "R4 or");
    issue(4'd8, 32'h1234_5678, 32'd0, "R4 not");
    issue(4'd2, 32'd3, 32'd5, "R3 sub borrow");
    allConds();
    issue(4'd4, 32'd5, 32'd5, "R5 cmp equal no write");
    allConds();
    issue(4'd4, 32'd0, 32'd1, "R5 cmp borrow");
    issue(4'd1, 32'hFFFF_FFFF, 32'd0, "R2 adc with carry in");
    issue(4'd4, 32'd0, 32'd1, "R5 cmp borrow again");
    issue(4'd3, 32'h8000_0000, 32'd0, "R3 sbb overflow from borrow in");
    allConds();
    issue(4'd3, 32'd10, 32'd3, "R3 sbb no borrow in");
    issue(4'd4, 32'hFFFF_FFFF, 32'd1, "R5 cmp signed -1 vs 1");
    allConds();
    issue(4'd12, 32'd0, 32'd0, "R6 unused opcode");
    idle(3);
    checkHold();
    issue(4'd2, 32'h8000_0000, 32'd1, "R3 sub neg minus pos");
    issue(4'd1, 32'h7FFF_FFFF, 32'h0000_0000, "R2 adc no carry in");
    allConds();
    idle(2);
    checkHold();

    checkTarget(32'h0000_1000, 8'h10);
    checkTarget(32'h0000_1000, 8'hFF);
    checkTarget(32'h0000_1000, 8'h80);
    checkTarget(32'h0000_0002, 8'h80);
    checkTarget(32'hFFFF_FFFE, 8'h7F);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule